// File: doc/BRIEF.md
# Prioritized Multi-Source Interrupt Controller

This block merges up to 64 external interrupt request lines into one interrupt output for a CPU. Software programs each line through a 32-bit register bus. It sets a trigger mode (low level, high level, falling edge or rising edge) and a priority level from 0 to 7, where 0 turns the line off. Edge events are held in per-line latches until software clears them by writing a coded index. The latch is not cleared by the input returning to its idle state.

A global enable bit and a priority threshold control what reaches the CPU. A line competes only when its level is nonzero and at least the threshold. The highest level wins, and a tie goes to the lowest line number. Line 0 exists but is never selected. A read-only status word carries a "nothing pending" flag and the number of the winning line. Every input passes through a synchronizer before mode handling. The interrupt output and the status word are registered.

Top module: `irqc_top`

## Requirements
- R1: After reset, irq_out is 0, the status word (address 0x08) reads 0x0001_0000, and the control, threshold, mode and level registers read 0.
- R2: Mode code 00 is active-low level: the line requests while its input is 0 and stops requesting once its input is 1.
- R3: Mode code 01 is active-high level: the line requests while its input is 1.
- R4: Mode codes 10 (falling) and 11 (rising) are edge modes. The configured edge on the input sets a latch, and the latch keeps requesting after the input returns to idle.
- R5: A write to address 0x02 (lines 0–31) or 0x03 (lines 32–63) clears edge latches. Bit 8 enables a clear of line index bits 3:0 within the first 16 lines of that half, and bit 24 with bits 19:16 does the same within the second 16. A word with the enable bit clear, a different index or the other address leaves the latch set.
- R6: A line is eligible only if its level is nonzero and greater than or equal to the threshold at address 0x01 (bits 2:0). A threshold of 0 blocks every line.
- R7: Among eligible lines, the highest level wins. On equal levels, the lowest line number wins. This applies to level and edge lines alike.
- R8: Line 0 is never reported, whatever its level, mode and input.
- R9: Bit 0 of address 0x00 enables the controller. While it is 0, irq_out is 0 and the status word reports nothing pending. The selection is restored once the bit is set again.
- R10: In the status word, bit 16 set means nothing pending and irq_out is 0. When bit 16 is clear, bits 5:0 hold the winning line number and irq_out is 1.
- R11: Mode register 0x04+k holds line 16k+j in bits 2j+1:2j. Level register 0x10+r holds line 4r+j in bits 8j+2:8j. Reads return only the stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Asynchronous interrupt request inputs, bit n is line n |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read enable; bus_rdata is 0 when low |
| bus_addr | input | 8 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 1 | Registered interrupt request to the CPU |

## Verification
The hardest state to reach from the ports is a set edge latch surviving a clear-style write. That write has to be almost right: the correct half but the wrong index, the correct index but the other half, or the enable bit missing. The stimulus pulses a line for a few cycles, returns the input to idle, and then issues each near-miss clear word. After each one it reads the status word to confirm that the line is still the winner, and only then sends the exact clear. Two edge lines with different levels are also latched together, so that clearing the winner exposes the latched runner-up.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int BUS_W         = 32;
   localparam int A_CTRL        = 'h00;
   localparam int A_THRESH      = 'h01;
   localparam int A_CLR_LO      = 'h02;
   localparam int A_CLR_HI      = 'h03;
   localparam int A_MODE        = 'h04;
   localparam int A_STATUS      = 'h08;
   localparam int A_LEVEL       = 'h10;
   localparam int STAT_NONE_BIT = 16;
   localparam int CLR_EN_BIT    = 8;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'b00,
      TRIG_HIGH = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_RISE = 2'b11
   } trig_e;
endpackage

// File: rtl/irqc_regfile.sv
module irqc_regfile
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int LVL_W   = 3,
   parameter int ADDR_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [BUS_W-1:0]         bus_wdata,
   output logic [BUS_W-1:0]         bus_rdata,
   input  logic [BUS_W-1:0]         status_word,
   output logic                     ctrl_en,
   output logic [LVL_W-1:0]         thresh,
   output logic [2*NUM_SRC-1:0]     mode_flat,
   output logic [LVL_W*NUM_SRC-1:0] lvl_flat,
   output logic [NUM_SRC-1:0]       clr_vec
);
   localparam int MODE_REGS = NUM_SRC / 16;
   localparam int LVL_REGS  = NUM_SRC / 4;
   localparam int HALVES    = NUM_SRC / 32;

   logic [BUS_W-1:0] rd_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b0;
         thresh    <= '0;
         mode_flat <= '0;
         lvl_flat  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(A_CTRL))   ctrl_en <= bus_wdata[0];
         if (bus_addr == ADDR_W'(A_THRESH)) thresh  <= bus_wdata[LVL_W-1:0];
         for (int k = 0; k < MODE_REGS; k++) begin
            if (bus_addr == ADDR_W'(A_MODE + k))
               mode_flat[k*32 +: 32] <= bus_wdata;
         end
         for (int r = 0; r < LVL_REGS; r++) begin
            if (bus_addr == ADDR_W'(A_LEVEL + r)) begin
               for (int j = 0; j < 4; j++)
                  lvl_flat[(4*r+j)*LVL_W +: LVL_W] <= bus_wdata[8*j +: LVL_W];
            end
         end
      end
   end

   // decoded one-cycle clear strobes, one per line
   always_comb begin
      clr_vec = '0;
      if (bus_wr) begin
         for (int h = 0; h < HALVES; h++) begin
            if (bus_addr == ADDR_W'(A_CLR_LO + h)) begin
               for (int g = 0; g < 2; g++) begin
                  if (bus_wdata[16*g + CLR_EN_BIT])
                     clr_vec[32*h + 16*g + int'(bus_wdata[16*g +: 4])] = 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(A_CTRL))   rd_mux[0] = ctrl_en;
      if (bus_addr == ADDR_W'(A_THRESH)) rd_mux[LVL_W-1:0] = thresh;
      if (bus_addr == ADDR_W'(A_STATUS)) rd_mux = status_word;
      for (int k = 0; k < MODE_REGS; k++) begin
         if (bus_addr == ADDR_W'(A_MODE + k)) rd_mux = mode_flat[k*32 +: 32];
      end
      for (int r = 0; r < LVL_REGS; r++) begin
         if (bus_addr == ADDR_W'(A_LEVEL + r)) begin
            for (int j = 0; j < 4; j++)
               rd_mux[8*j +: LVL_W] = lvl_flat[(4*r+j)*LVL_W +: LVL_W];
         end
      end
   end

   assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/irqc_line.sv
module irqc_line
   import irqc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] mode,
   input  logic       clr,
   output logic       req,
   output logic       lat
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   latch_q;
   logic                   cur;
   logic                   edge_mode;
   logic                   hit;

   assign cur       = sync_q[SYNC_STAGES-1];
   assign edge_mode = mode[1];
   assign hit       = (mode == TRIG_RISE) ? (cur & ~prev_q) : (~cur & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= cur;
         if (!edge_mode)   latch_q <= 1'b0;
         else if (hit)     latch_q <= 1'b1;
         else if (clr)     latch_q <= 1'b0;
      end
   end

   assign req = edge_mode ? latch_q : (mode[0] ? cur : ~cur);
   assign lat = latch_q;
endmodule

// File: rtl/irqc_prio_select.sv
module irqc_prio_select #(
   parameter int N        = 64,
   parameter int LVL_W    = 3,
   parameter bit SEL_TREE = 1'b1,
   localparam int IDW     = $clog2(N)
) (
   input  logic [N-1:0]       elig,
   input  logic [LVL_W*N-1:0] lvl_flat,
   output logic               sel_v,
   output logic [IDW-1:0]     sel_id
);
   generate
      if (SEL_TREE) begin : g_tree
         localparam int NODES = 2*N - 1;
         logic             hv [NODES];
         logic [LVL_W-1:0] hl [NODES];
         logic [IDW-1:0]   hi [NODES];
         for (genvar i = 0; i < N; i++) begin : g_leaf
            assign hv[N-1+i] = elig[i];
            assign hl[N-1+i] = lvl_flat[i*LVL_W +: LVL_W];
            assign hi[N-1+i] = IDW'(i);
         end
         for (genvar k = 0; k < N-1; k++) begin : g_node
            logic take_r;
            // left subtree holds lower line numbers, so it keeps ties
            assign take_r = hv[2*k+2] && (!hv[2*k+1] || (hl[2*k+2] > hl[2*k+1]));
            assign hv[k]  = hv[2*k+1] | hv[2*k+2];
            assign hl[k]  = take_r ? hl[2*k+2] : hl[2*k+1];
            assign hi[k]  = take_r ? hi[2*k+2] : hi[2*k+1];
         end
         assign sel_v  = hv[0];
         assign sel_id = hi[0];
      end else begin : g_linear
         logic             v;
         logic [LVL_W-1:0] bl;
         logic [IDW-1:0]   bi;
         always_comb begin
            v  = 1'b0;
            bl = '0;
            bi = '0;
            for (int i = N-1; i >= 0; i--) begin
               if (elig[i] && (!v || (lvl_flat[i*LVL_W +: LVL_W] >= bl))) begin
                  v  = 1'b1;
                  bl = lvl_flat[i*LVL_W +: LVL_W];
                  bi = IDW'(i);
               end
            end
         end
         assign sel_v  = v;
         assign sel_id = bi;
      end
   endgenerate
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int NUM_SRC     = 64,
   parameter int LVL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit SEL_TREE    = 1'b1,
   parameter int ADDR_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   output logic               irq_out
);
   localparam int IDW = $clog2(NUM_SRC);
   localparam logic [NUM_SRC-1:0] USE_MASK = ~NUM_SRC'(1);

   generate
      if (!(NUM_SRC == 32 || NUM_SRC == 64)) begin : g_bad_num
         $error("irqc_top: NUM_SRC must be 32 or 64");
      end
      if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
         $error("irqc_top: LVL_W must be 1 to 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irqc_top: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("irqc_top: ADDR_W too small for the register map");
      end
   endgenerate

   logic                     ctrl_en;
   logic [LVL_W-1:0]         thresh;
   logic [2*NUM_SRC-1:0]     mode_flat;
   logic [LVL_W*NUM_SRC-1:0] lvl_flat;
   logic [NUM_SRC-1:0]       clr_vec;
   logic [NUM_SRC-1:0]       req;
   logic [NUM_SRC-1:0]       edge_lat;
   logic [NUM_SRC-1:0]       is_edge;
   logic [NUM_SRC-1:0]       elig;
   logic                     sel_v;
   logic [IDW-1:0]           sel_id;
   logic                     irq_q;
   logic                     none_q;
   logic [IDW-1:0]           id_q;
   logic [BUS_W-1:0]         status_word;

   irqc_regfile #(
      .NUM_SRC (NUM_SRC),
      .LVL_W   (LVL_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .status_word (status_word),
      .ctrl_en     (ctrl_en),
      .thresh      (thresh),
      .mode_flat   (mode_flat),
      .lvl_flat    (lvl_flat),
      .clr_vec     (clr_vec)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
      logic [LVL_W-1:0] lvl_i;
      assign lvl_i      = lvl_flat[i*LVL_W +: LVL_W];
      assign is_edge[i] = mode_flat[2*i+1];

      irqc_line #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_line (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (irq_in[i]),
         .mode  (mode_flat[2*i +: 2]),
         .clr   (clr_vec[i]),
         .req   (req[i]),
         .lat   (edge_lat[i])
      );

      assign elig[i] = USE_MASK[i] & req[i] & (lvl_i != '0) &
                       (thresh != '0) & (lvl_i >= thresh);
   end

   irqc_prio_select #(
      .N        (NUM_SRC),
      .LVL_W    (LVL_W),
      .SEL_TREE (SEL_TREE)
   ) u_sel (
      .elig     (elig),
      .lvl_flat (lvl_flat),
      .sel_v    (sel_v),
      .sel_id   (sel_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         none_q <= 1'b1;
         id_q   <= '0;
      end else begin
         irq_q  <= ctrl_en & sel_v;
         none_q <= ~(ctrl_en & sel_v);
         id_q   <= (ctrl_en & sel_v) ? sel_id : '0;
      end
   end

   always_comb begin
      status_word                = '0;
      status_word[STAT_NONE_BIT] = none_q;
      status_word[IDW-1:0]       = id_q;
   end

   assign irq_out = irq_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int NUM_SRC = 64,
   parameter int LVL_W   = 3,
   localparam int IDW    = $clog2(NUM_SRC)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     irq_out,
   input logic                     none_q,
   input logic [IDW-1:0]           id_q,
   input logic                     ctrl_en,
   input logic [LVL_W-1:0]         thresh,
   input logic [LVL_W*NUM_SRC-1:0] lvl_flat,
   input logic [NUM_SRC-1:0]       edge_lat,
   input logic [NUM_SRC-1:0]       clr_vec,
   input logic [NUM_SRC-1:0]       is_edge
);
   logic [LVL_W*NUM_SRC-1:0] lvl_d;
   logic [LVL_W-1:0]         thresh_d;
   logic [LVL_W-1:0]         win_lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d    <= '0;
         thresh_d <= '0;
      end else begin
         lvl_d    <= lvl_flat;
         thresh_d <= thresh;
      end
   end

   assign win_lvl_d = lvl_d[id_q*LVL_W +: LVL_W];

   // R9
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> !irq_out);

   // R6
   thresh_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh == '0) |=> !irq_out);

   // R8
   no_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !none_q |-> (id_q != '0));

   // R6
   winner_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !none_q |-> ((win_lvl_d != '0) && (win_lvl_d >= thresh_d)));

   // R4
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(edge_lat) & ~$past(clr_vec) & $past(is_edge) & is_edge & ~edge_lat) == '0));
endmodule

bind irqc_top irqc_chk #(
   .NUM_SRC (NUM_SRC),
   .LVL_W   (LVL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_out  (irq_out),
   .none_q   (none_q),
   .id_q     (id_q),
   .ctrl_en  (ctrl_en),
   .thresh   (thresh),
   .lvl_flat (lvl_flat),
   .edge_lat (edge_lat),
   .clr_vec  (clr_vec),
   .is_edge  (is_edge)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
   localparam int N = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_out;

   always #2 clk = ~clk;

   irqc_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   typedef struct {
      logic [31:0] data;
      bit          chk_irq;
      logic        exp_irq;
      string       tag;
   } item_t;

   item_t sbq[$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   // monitor: compares each read against the queued expectation
   always @(negedge clk) begin
      item_t it;
      if (bus_rd && sbq.size() > 0) begin
         it = sbq.pop_front();
         checks++;
         if (bus_rdata !== it.data) begin
            fails++;
            $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.data);
         end
         if (it.chk_irq) begin
            checks++;
            if (irq_out !== it.exp_irq) begin
               fails++;
               $display("FAIL %s: irq_out=%b expected %b", it.tag, irq_out, it.exp_irq);
            end
         end
      end
   end

   task automatic settle();
      repeat (6) @(posedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      settle();
   endtask

   task automatic pin(input int k, input logic v);
      @(posedge clk); #1;
      irq_in[k] = v;
      settle();
   endtask

   task automatic expect_rd(input int a, input logic [31:0] d, input bit ci,
                            input logic ei, input string tag);
      item_t it;
      it.data = d; it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
      @(posedge clk); #1;
      bus_rd = 1'b1; bus_addr = 8'(a);
      sbq.push_back(it);
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   // id < 0 means nothing pending
   task automatic expect_status(input int id, input string tag);
      if (id < 0) expect_rd('h08, 32'h0001_0000, 1'b1, 1'b0, tag);
      else        expect_rd('h08, 32'(id), 1'b1, 1'b1, tag);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (all requirements): run unfinished, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      irq_in     = '1;
      irq_in[40] = 1'b0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();

      // R1 reset state
      expect_status(-1, "R1 status after reset");
      expect_rd('h00, 32'h0, 1'b0, 1'b0, "R1 ctrl reset");
      expect_rd('h01, 32'h0, 1'b0, 1'b0, "R1 threshold reset");
      expect_rd('h06, 32'h0, 1'b0, 1'b0, "R1 mode reset");
      expect_rd('h1F, 32'h0, 1'b0, 1'b0, "R1 level reset");

      wr('h00, 32'h1);
      wr('h01, 32'h1);
      wr('h11, 32'h0000_0300);           // line 5 level 3
      expect_status(-1, "R2 idle high, no request");
      pin(5, 1'b0);
      expect_status(5, "R2 low level requests");
      expect_rd('h11, 32'h0000_0300, 1'b0, 1'b0, "R11 level readback");
      wr('h1F, 32'hFFFF_FFFF);
      expect_rd('h1F, 32'h0707_0707, 1'b0, 1'b0, "R11 level stored bits only");
      wr('h1F, 32'h0);

      // R3 line 40 active high, level 2
      wr('h06, 32'h0001_0000);
      wr('h1A, 32'h0000_0002);
      expect_status(5, "R3 high mode, input low");
      expect_rd('h06, 32'h0001_0000, 1'b0, 1'b0, "R11 mode readback");
      pin(40, 1'b1);
      expect_status(5, "R7 level 3 beats level 2");
      pin(5, 1'b1);
      expect_status(40, "R3 high level requests");
      pin(5, 1'b0);
      wr('h1A, 32'h0000_0003);
      expect_status(5, "R7 tie goes to lower line");
      wr('h1A, 32'h0000_0007);
      expect_status(40, "R7 higher level wins");

      // R6 threshold
      wr('h01, 32'h7);
      expect_status(40, "R6 level equal to threshold 7");
      wr('h01, 32'h0);
      expect_status(-1, "R6 threshold 0 blocks all");
      wr('h01, 32'h4);
      expect_status(40, "R6 threshold 4");
      wr('h1A, 32'h0);
      expect_status(-1, "R6 level 0 off and level 3 below threshold");
      wr('h01, 32'h3);
      expect_status(5, "R6 level equal to threshold 3");
      pin(40, 1'b0);
      pin(5, 1'b1);
      expect_status(-1, "R2 input back high");

      // R8 line 0
      wr('h10, 32'h0000_0007);
      pin(0, 1'b0);
      expect_status(-1, "R8 line 0 never reported");
      wr('h10, 32'h0);
      pin(0, 1'b1);

      // R4 rising edge on line 20, level 4
      pin(20, 1'b0);
      wr('h05, 32'h0000_0300);
      wr('h15, 32'h0000_0004);
      expect_status(-1, "R4 no edge yet");
      @(posedge clk); #1 irq_in[20] = 1'b1;
      repeat (3) @(posedge clk);
      #1 irq_in[20] = 1'b0;
      settle();
      expect_status(20, "R4 rising latch held after idle");
      wr('h02, 32'h0105_0000);
      expect_status(20, "R5 other index keeps latch");
      wr('h02, 32'h0004_0000);
      expect_status(20, "R5 enable bit clear keeps latch");
      wr('h03, 32'h0104_0000);
      expect_status(20, "R5 other half keeps latch");
      wr('h02, 32'h0104_0000);
      expect_status(-1, "R5 exact clear");

      // R4 falling edge on line 9, level 6
      wr('h04, 32'h0008_0000);
      wr('h12, 32'h0000_0600);
      pin(9, 1'b0);
      expect_status(9, "R4 falling latch");
      pin(9, 1'b1);
      expect_status(9, "R4 falling latch held");
      wr('h02, 32'h0000_0109);
      expect_status(-1, "R5 clear low group");

      // line 50 falling, level 5
      wr('h07, 32'h0000_0020);
      wr('h1C, 32'h0005_0000);
      pin(50, 1'b0);
      expect_status(50, "R4 falling latch upper half");
      pin(50, 1'b1);
      pin(9, 1'b0);
      pin(9, 1'b1);
      expect_status(9, "R7 latched level 6 beats latched 5");
      wr('h02, 32'h0000_0109);
      expect_status(50, "R7 runner-up exposed after clear");
      wr('h03, 32'h0102_0000);
      expect_status(-1, "R5 clear upper half");

      // R9 global enable
      pin(5, 1'b0);
      expect_status(5, "R9 enabled");
      wr('h00, 32'h0);
      expect_status(-1, "R9 disabled");
      expect_rd('h00, 32'h0, 1'b0, 1'b0, "R9 ctrl readback");
      wr('h00, 32'h1);
      expect_status(5, "R10 status after re-enable");

      repeat (4) @(posedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule